// File: doc/BRIEF.md
# IEEE Double Operand Screening Unit

This unit sits in front of a double-precision floating-point datapath and inspects each 64-bit operand before the arithmetic sees it. Depending on a per-operand policy select, it either passes the operand on, replaces a tiny operand with a signed zero, or asks for an arithmetic trap and reports why. The arithmetic operation itself lies downstream and is not part of this unit.

Three policies exist. The arithmetic policy rejects every non-finite value. The comparison policy rejects only NaNs and lets infinities through. The software-completion policy never traps and only performs the optional flush of zero-exponent values. In both trapping policies, a denormal is flushed to a signed zero when flushing is enabled and traps as underflow when it is not. The unit is a single registered stage with a valid strobe travelling alongside the data.

Top module: `operand_screen`

## Requirements
- R1: After a cycle with `rst` high, `out_valid`, `out_trap` and `out_cause` are all 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_trap` is never high without `out_valid`. `out_cause` is 0 whenever `out_trap` is low. A non-finite operand presented with `in_valid` low raises no trap.
- R3: An operand with exponent bits 62:52 neither all zeros nor all ones, or equal to +0 or -0, leaves the unit unchanged and without a trap under every policy.
- R4: Under policy 0 (arithmetic) or 1 (compare), a denormal (exponent bits 62:52 zero, fraction bits 51:0 nonzero) with `in_dnz`=1 comes out as its sign bit 63 with all other bits cleared, and no trap.
- R5: Under policy 0 or 1, a denormal with `in_dnz`=0 raises a trap with cause 1 (underflow), and the data passes unchanged.
- R6: Under policy 0, a NaN (exponent all ones, fraction nonzero) raises a trap with cause 2 (invalid), and the data passes unchanged.
- R7: Under policy 0, an infinity (exponent all ones, fraction zero) raises a trap with cause 3 (overflow), and the data passes unchanged.
- R8: Under policy 1, a NaN raises a trap with cause 2, and an infinity passes unchanged without a trap.
- R9: Under policy 2 or 3 (software completion), no trap is ever raised. With `in_dnz`=1, a zero exponent yields the sign bit alone. With `in_dnz`=0, denormals, NaNs and infinities pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 64 | IEEE double operand |
| in_mode | input | 2 | Policy: 0 arithmetic, 1 compare, 2 and 3 software completion |
| in_dnz | input | 1 | Flush zero-exponent inputs to signed zero |
| out_valid | output | 1 | Screened operand present |
| out_data | output | 64 | Screened operand |
| out_trap | output | 1 | Trap request, qualified by out_valid |
| out_cause | output | 2 | Trap cause: 0 none, 1 underflow, 2 invalid, 3 overflow |

## Verification
The clocked properties compare `out_data` with the value `in_data` had one cycle earlier. They therefore assume that `in_valid`, `in_data`, `in_mode` and `in_dnz` are stable across each sampling edge, and that `in_valid` is low while `rst` is high. The stimulus meets these assumptions by changing every input only on the falling edge, by holding `in_valid` low throughout reset, and by presenting operands back to back so that each output cycle lines up with exactly one input cycle.

// File: rtl/screen_pkg.sv
package screen_pkg;

  typedef enum logic [1:0] {
    POL_ARITH = 2'd0,
    POL_CMP   = 2'd1,
    POL_SWC   = 2'd2,
    POL_SWC_B = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_UNF  = 2'd1,
    CAUSE_INV  = 2'd2,
    CAUSE_OVF  = 2'd3
  } cause_e;

  typedef struct packed {
    logic sign;
    logic exp_zero;
    logic exp_max;
    logic frac_nz;
  } op_class_t;

endpackage

// File: rtl/screen_classify.sv
module screen_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output screen_pkg::op_class_t cls
);
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op[DATA_W-2 -: EXP_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    cls.sign     = op[DATA_W-1];
    cls.exp_zero = (exp_f == '0);
    cls.exp_max  = (exp_f == '1);
    cls.frac_nz  = (frac_f != '0);
  end

  // r3_: the two exponent classes never overlap
  always_comb begin
    assert (!(cls.exp_zero && cls.exp_max));
  end
endmodule

// File: rtl/screen_policy.sv
module screen_policy #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]  op,
  input  screen_pkg::op_class_t  cls,
  input  logic [1:0]             mode,
  input  logic                   dnz,
  output logic [EXP_W+FRAC_W:0]  res,
  output logic                   trap,
  output logic [1:0]             cause
);
  import screen_pkg::*;
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  logic swc;
  logic flush;

  assign swc = mode[1];

  always_comb begin
    flush = dnz && cls.exp_zero && (swc || cls.frac_nz);
    res   = flush ? {cls.sign, {(DATA_W-1){1'b0}}} : op;
    trap  = 1'b0;
    cause = CAUSE_NONE;
    if (!swc) begin
      if (cls.exp_zero && cls.frac_nz && !dnz) begin
        trap  = 1'b1;
        cause = CAUSE_UNF;
      end else if (cls.exp_max && cls.frac_nz) begin
        trap  = 1'b1;
        cause = CAUSE_INV;
      end else if (cls.exp_max && mode == POL_ARITH) begin
        trap  = 1'b1;
        cause = CAUSE_OVF;
      end
    end
  end
endmodule

// File: rtl/operand_screen.sv
module operand_screen #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [EXP_W+FRAC_W:0]      in_data,
  input  logic [1:0]                 in_mode,
  input  logic                       in_dnz,
  output logic                       out_valid,
  output logic [EXP_W+FRAC_W:0]      out_data,
  output logic                       out_trap,
  output logic [1:0]                 out_cause
);
  import screen_pkg::*;
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  op_class_t         cls;
  logic [DATA_W-1:0] res;
  logic              trap_c;
  logic [1:0]        cause_c;

  screen_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .op  (in_data),
    .cls (cls)
  );

  screen_policy #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_policy (
    .op    (in_data),
    .cls   (cls),
    .mode  (in_mode),
    .dnz   (in_dnz),
    .res   (res),
    .trap  (trap_c),
    .cause (cause_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_trap  <= 1'b0;
      out_cause <= CAUSE_NONE;
    end else begin
      out_valid <= in_valid;
      out_trap  <= in_valid && trap_c;
      out_cause <= (in_valid && trap_c) ? cause_c : CAUSE_NONE;
      if (in_valid) out_data <= res;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_trap_qualified_r2: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> out_valid);
  p_cause_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !out_trap |-> out_cause == CAUSE_NONE);
  p_normal_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[DATA_W-2 -: EXP_W] != '0 && in_data[DATA_W-2 -: EXP_W] != '1)
    |=> (!out_trap && out_data == $past(in_data)));
  p_cmp_inf_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == POL_CMP && in_data[DATA_W-2 -: EXP_W] == '1
     && in_data[FRAC_W-1:0] == '0)
    |=> (!out_trap && out_data == $past(in_data)));
  p_swc_no_trap_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode[1]) |=> !out_trap);
endmodule

// File: tb/operand_screen_bench.sv
module operand_screen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0]  in_mode = '0;
  logic        in_dnz = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_trap;
  logic [1:0]  out_cause;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  operand_screen u_operand_screen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .in_dnz(in_dnz), .out_valid(out_valid),
    .out_data(out_data), .out_trap(out_trap), .out_cause(out_cause)
  );

  // {req, mode, dnz, operand, expected data, expected trap, expected cause}
  localparam int NV = 20;
  localparam logic [141:0] VECS [0:NV-1] = '{
    {8'd3, 2'd0, 1'b0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 2'd0}, // R3
    {8'd3, 2'd1, 1'b1, 64'hC004_0000_0000_0000, 64'hC004_0000_0000_0000, 1'b0, 2'd0}, // R3
    {8'd3, 2'd2, 1'b0, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 2'd0}, // R3
    {8'd3, 2'd0, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'd0}, // R3
    {8'd3, 2'd1, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 2'd0}, // R3
    {8'd4, 2'd0, 1'b1, 64'h800F_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, 2'd0}, // R4
    {8'd4, 2'd1, 1'b1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b0, 2'd0}, // R4
    {8'd5, 2'd0, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b1, 2'd1}, // R5
    {8'd5, 2'd1, 1'b0, 64'h8008_0000_0000_0000, 64'h8008_0000_0000_0000, 1'b1, 2'd1}, // R5
    {8'd6, 2'd0, 1'b0, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1'b1, 2'd2}, // R6
    {8'd6, 2'd0, 1'b1, 64'hFFF0_0000_0000_0001, 64'hFFF0_0000_0000_0001, 1'b1, 2'd2}, // R6
    {8'd7, 2'd0, 1'b0, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b1, 2'd3}, // R7
    {8'd7, 2'd0, 1'b1, 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b1, 2'd3}, // R7
    {8'd8, 2'd1, 1'b0, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1'b1, 2'd2}, // R8
    {8'd8, 2'd1, 1'b0, 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0, 2'd0}, // R8
    {8'd9, 2'd2, 1'b1, 64'h800F_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, 2'd0}, // R9
    {8'd9, 2'd3, 1'b1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b0, 2'd0}, // R9
    {8'd9, 2'd2, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0, 2'd0}, // R9
    {8'd9, 2'd3, 1'b0, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 1'b0, 2'd0}, // R9
    {8'd9, 2'd2, 1'b1, 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0, 2'd0}  // R9
  };

  task automatic check(input int req, input logic v, input logic [63:0] d,
                       input logic t, input logic [1:0] c, input logic cmp_data);
    checks++;
    if (out_valid !== v || out_trap !== t || out_cause !== c ||
        (cmp_data && out_data !== d)) begin
      fails++;
      $display("FAIL R%0d: got valid=%b data=%h trap=%b cause=%0d, expected valid=%b data=%h trap=%b cause=%0d",
               req, out_valid, out_data, out_trap, out_cause, v, d, t, c);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 64'h0, 1'b0, 2'd0, 1'b0); // R1 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_mode  = VECS[i][133:132];
      in_dnz   = VECS[i][131];
      in_data  = VECS[i][130:67];
      in_valid = 1'b1;
      @(negedge clk);
      check(int'(VECS[i][141:134]), 1'b1, VECS[i][66:3], VECS[i][2], VECS[i][1:0], 1'b1);
    end

    // R2: valid drops one cycle after in_valid drops
    in_valid = 1'b0;
    in_mode  = 2'd0;
    in_data  = 64'h7FF8_0000_0000_0000;
    @(negedge clk);
    check(2, 1'b0, 64'h0, 1'b0, 2'd0, 1'b0);
    // R2: non-finite operand without in_valid raises nothing
    @(negedge clk);
    check(2, 1'b0, 64'h0, 1'b0, 2'd0, 1'b0);

    // R2: trap then a clean operand, cause returns to zero
    in_valid = 1'b1;
    in_data  = 64'h7FF0_0000_0000_0000;
    @(negedge clk);
    check(2, 1'b1, 64'h7FF0_0000_0000_0000, 1'b1, 2'd3, 1'b1);
    in_data  = 64'h4000_0000_0000_0000;
    @(negedge clk);
    check(2, 1'b1, 64'h4000_0000_0000_0000, 1'b0, 2'd0, 1'b1);

    // R1: reset in the middle of a stream clears the outputs
    in_data = 64'h0000_0000_0000_0001;
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 64'h0, 1'b0, 2'd0, 1'b1);
    rst = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule